// File: doc/BRIEF.md
# Revolution Marker Periodicity Checker

This block watches a synchronized once-per-turn reference pulse that flags the first bunch slot of each machine revolution. It expects the pulse to return after exactly `PERIOD` system clock cycles (120 by default). Each cycle it produces a two-bit control code for the downstream history buffers. The code says whether a pulse has just arrived and whether its spacing was right. It also says when an expected pulse failed to show up.

A slot counter numbers the bunch positions within the turn. The counter restarts on every accepted rising edge. When the pulse is absent it wraps by itself, so the numbering survives noise. A small saturating counter tallies spacing faults and can be cleared synchronously. After reset, the first rising edge seen is taken as the phase reference without any spacing check.

Top module: `rev_marker_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `ctrl_code`=00, `slot`=0 and `fault_cnt`=0.
- R2: After reset, and before the first rising edge of `marker`, `ctrl_code` stays 00 and `slot` stays 0. The first rising edge produces code 01, sets `slot` to 0 and adds no fault.
- R3: Once locked, a rising edge that arrives exactly `PERIOD` cycles after the previous accepted edge produces code 01 (good marker).
- R4: Once locked, a rising edge at any other spacing, early or late, produces code 10 (bad spacing). It also resynchronizes `slot` to 0.
- R5: Once locked, if no rising edge is seen on the cycle where `slot` would reach `PERIOD`, the block produces code 11 (missing marker) and `slot` wraps to 0.
- R6: With the marker absent, the block keeps running freely. It reports code 11 once every `PERIOD` cycles and code 00 on all other cycles.
- R7: Only the rising edge counts. A marker held high for several cycles gives a single 01 or 10 code, followed by 00 codes.
- R8: Once locked, `slot` advances by one each cycle, modulo `PERIOD`, and never exceeds `PERIOD`-1.
- R9: `fault_cnt` increments on each cycle whose code is 10 or 11, and saturates at 2^`ERR_W`-1.
- R10: `fault_clr` high at a clock edge sets `fault_cnt` to 0 and overrides a simultaneous increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one cycle per bunch slot |
| rst_n | input | 1 | Synchronous reset, active low |
| marker | input | 1 | Synchronized revolution reference pulse |
| fault_clr | input | 1 | Synchronous clear of the fault counter |
| ctrl_code | output | 2 | 00 idle, 01 good marker, 10 bad spacing, 11 missing marker |
| slot | output | $clog2(PERIOD) | Bunch slot number within the revolution |
| fault_cnt | output | ERR_W | Saturating count of 10 and 11 codes |

## Verification
The bench sweeps every second-edge spacing from 2 to `PERIOD`+5 cycles after the reference edge.
- A design that measured the period one cycle off would flag the exact spacing as 10, or accept a neighbouring spacing.
- A design that failed to report 11 before a late edge would lose the slot numbering.

Other runs target specific corners:
- A marker held high for several cycles: a level-sensitive design would report one code per high cycle.
- A long stretch with no marker, to check that 11 repeats once per turn.
- Driving the fault counter past saturation: a design that wraps would roll over to 0.
- A clear that coincides with a miss: a design where the increment wins would read 1 instead of 0.

// File: rtl/rmc_pkg.sv
package rmc_pkg;
   typedef enum logic [1:0] {
      CODE_IDLE  = 2'b00,
      CODE_GOOD  = 2'b01,
      CODE_WRONG = 2'b10,
      CODE_MISS  = 2'b11
   } mark_code_e;
endpackage

// File: rtl/rmc_edge.sv
module rmc_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic rise
);
   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_in;
   end

   assign rise = level_in & ~level_q;
endmodule

// File: rtl/rmc_slot_ctr.sv
module rmc_slot_ctr
   import rmc_pkg::*;
#(
   parameter int PERIOD = 120,
   parameter int CNT_W  = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic [CNT_W-1:0] slot_q,
   output mark_code_e       code_q,
   output mark_code_e       code_d
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

   logic             locked_q, locked_d;
   logic [CNT_W-1:0] slot_d;
   logic             at_end;

   assign at_end = locked_q && (slot_q == LAST);

   always_comb begin
      locked_d = locked_q;
      slot_d   = slot_q;
      code_d   = CODE_IDLE;
      if (!locked_q) begin
         if (rise) begin
            locked_d = 1'b1;
            slot_d   = '0;
            code_d   = CODE_GOOD;
         end
      end else if (rise) begin
         slot_d = '0;
         code_d = at_end ? CODE_GOOD : CODE_WRONG;
      end else if (at_end) begin
         slot_d = '0;
         code_d = CODE_MISS;
      end else begin
         slot_d = slot_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         slot_q   <= '0;
         code_q   <= CODE_IDLE;
      end else begin
         locked_q <= locked_d;
         slot_q   <= slot_d;
         code_q   <= code_d;
      end
   end

   a_r8_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
      slot_q <= LAST);

   a_r2_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
      !locked_q |-> (code_q == CODE_IDLE && slot_q == '0));
endmodule

// File: rtl/rmc_err_ctr.sv
module rmc_err_ctr #(
   parameter int ERR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bump,
   output logic [ERR_W-1:0] cnt_q
);
   localparam logic [ERR_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (clr)                        cnt_q <= '0;
      else if (bump && cnt_q != CNT_MAX)   cnt_q <= cnt_q + 1'b1;
   end

   a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr) |-> cnt_q == '0);

   a_r9_step_or_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ##1 (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
endmodule

// File: rtl/rev_marker_checker.sv
module rev_marker_checker
   import rmc_pkg::*;
#(
   parameter int PERIOD = 120,
   parameter int ERR_W  = 8,
   localparam int CNT_W = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             marker,
   input  logic             fault_clr,
   output logic [1:0]       ctrl_code,
   output logic [CNT_W-1:0] slot,
   output logic [ERR_W-1:0] fault_cnt
);
   generate
      if (PERIOD < 2) begin : g_bad_period
         $error("rev_marker_checker: PERIOD must be at least 2");
      end
      if (ERR_W < 1) begin : g_bad_err_w
         $error("rev_marker_checker: ERR_W must be at least 1");
      end
   endgenerate

   logic       rise;
   mark_code_e code_q, code_d;
   logic       is_fault;

   rmc_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (marker),
      .rise     (rise)
   );

   rmc_slot_ctr #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (rise),
      .slot_q (slot),
      .code_q (code_q),
      .code_d (code_d)
   );

   assign is_fault = (code_d == CODE_WRONG) || (code_d == CODE_MISS);

   rmc_err_ctr #(.ERR_W(ERR_W)) u_err (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fault_clr),
      .bump  (is_fault),
      .cnt_q (fault_cnt)
   );

   assign ctrl_code = code_q;

   a_r5_miss_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_code == 2'b11) |-> (slot == '0));

   a_r4_edge_resyncs: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_code == 2'b01 || ctrl_code == 2'b10) |-> (slot == '0));

   a_r7_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_code == 2'b01 || ctrl_code == 2'b10) |=>
         !(ctrl_code == 2'b01 || ctrl_code == 2'b10));
endmodule

// File: tb/rev_marker_checker_tb.sv
module rev_marker_checker_tb;
   localparam int P  = 120;
   localparam int EW = 3;
   localparam int CW = $clog2(P);
   localparam int EMAX = (1 << EW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          marker = 1'b0;
   logic          fault_clr = 1'b0;
   logic [1:0]    ctrl_code;
   logic [CW-1:0] slot;
   logic [EW-1:0] fault_cnt;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   rev_marker_checker #(.PERIOD(P), .ERR_W(EW)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .marker    (marker),
      .fault_clr (fault_clr),
      .ctrl_code (ctrl_code),
      .slot      (slot),
      .fault_cnt (fault_cnt)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic tick(input logic m);
      marker = m;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      fault_clr = 1'b0;
      tick(1'b0);
      tick(1'b0);
      chk("R1", "code", int'(ctrl_code), 0);
      chk("R1", "slot", int'(slot), 0);
      chk("R1", "fault_cnt", int'(fault_cnt), 0);
      rst_n = 1'b1;
   endtask

   task automatic spacing(input int k);
      do_reset();
      tick(1'b1);
      chk("R2", "first edge code", int'(ctrl_code), 1);
      chk("R2", "first edge slot", int'(slot), 0);
      chk("R2", "first edge fault_cnt", int'(fault_cnt), 0);
      for (int n = 1; n < k; n++) begin
         tick(1'b0);
         chk("R5", "code while waiting", int'(ctrl_code), (n % P == 0) ? 3 : 0);
         chk("R8", "slot count", int'(slot), n % P);
      end
      tick(1'b1);
      if (k == P)     chk("R3", "exact spacing code", int'(ctrl_code), 1);
      else            chk("R4", "bad spacing code", int'(ctrl_code), 2);
      chk("R4", "slot after edge", int'(slot), 0);
      chk("R9", "fault_cnt after edge", int'(fault_cnt), (k < P) ? 1 : ((k == P) ? 0 : 2));
      tick(1'b0);
      chk("R8", "slot after resync", int'(slot), 1);
      chk("R7", "code after pulse", int'(ctrl_code), 0);
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      do_reset();

      // R2: no lock without an edge
      for (int n = 0; n < 2 * P; n++) begin
         tick(1'b0);
         chk("R2", "unlocked code", int'(ctrl_code), 0);
         chk("R2", "unlocked slot", int'(slot), 0);
      end

      // R3 R4 R5: sweep of edge spacings
      for (int k = 2; k <= P + 5; k++) spacing(k);

      // R7: wide marker counts once
      do_reset();
      for (int n = 0; n < 4; n++) begin
         tick(1'b1);
         chk("R7", "wide marker code", int'(ctrl_code), (n == 0) ? 1 : 0);
         chk("R7", "wide marker slot", int'(slot), n);
      end
      for (int n = 4; n < P; n++) tick(1'b0);
      tick(1'b1);
      chk("R7", "period from first edge", int'(ctrl_code), 1);
      chk("R7", "fault_cnt", int'(fault_cnt), 0);

      // R6: free running with absent marker, then R9 saturation
      do_reset();
      tick(1'b1);
      for (int n = 1; n <= 10 * P; n++) begin
         tick(1'b0);
         chk("R6", "free-run code", int'(ctrl_code), (n % P == 0) ? 3 : 0);
         chk("R6", "free-run slot", int'(slot), n % P);
         if (n % P == 0)
            chk("R9", "fault_cnt saturating", int'(fault_cnt), (n / P > EMAX) ? EMAX : n / P);
      end

      // R10: clear coincident with a miss wins
      for (int n = 1; n < P; n++) tick(1'b0);
      fault_clr = 1'b1;
      tick(1'b0);
      chk("R10", "miss code at clear", int'(ctrl_code), 3);
      chk("R10", "fault_cnt cleared", int'(fault_cnt), 0);
      fault_clr = 1'b0;
      for (int n = 0; n < P; n++) tick(1'b0);
      chk("R10", "count resumes", int'(fault_cnt), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule